// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Unit with Excess Word

This block performs the arithmetic, logic, shift and compare operations of a small 16-bit processor. It takes a 5-bit opcode and two operands, `b` (the destination-side operand) and `a` (the source-side operand). It returns three things:

- a result for `b`;
- a 16-bit excess word that the surrounding core writes into its excess register;
- a skip flag that the core uses to drop the following instruction.

The excess word is more than a carry bit. It holds the high half of a product, the fraction of a division, or the bits that a shift pushed out.

Operand fetch, writeback and skip chaining belong to the caller. The caller pulses `start` while `busy` is low. The unit latches the opcode and operands, then spends the opcode's cycle cost before it raises `done` for one cycle. On that cycle the outputs hold the answer, and they keep it until the next accepted start. Write enables tell the caller which of the result and excess word carry meaning.

The controller has three states: `ST_IDLE`, `ST_RUN` and `ST_FIN`. It moves through them as follows:

- `ST_IDLE` goes to `ST_FIN` on a start whose cost is one cycle.
- `ST_IDLE` goes to `ST_RUN` on any other start.
- `ST_RUN` stays where it is, counting elapsed cycles, until the count reaches the cost. It then goes to `ST_FIN`.
- `ST_FIN` always returns to `ST_IDLE`.

For a conditional test, the cost depends on the outcome: 2 cycles when the condition holds and 3 when it fails.

Top module: `exalu_core`

## Requirements
- R1: `start` is accepted only when `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. `done` is a one-cycle pulse. A `start` seen while `busy` is high has no effect on the outputs.
- R2: The latency is counted from the accepting clock edge, and `done` is seen after edge N-1, where N is the cycle cost: 1 for SET, AND, BOR, XOR, SHR, ASR, SHL and undefined codes; 2 for ADD, SUB, MUL and MLI; 3 for DIV, DVI, MOD and MDI; 2 for a conditional test whose condition holds and 3 when it fails.
- R3: Opcode encoding (5 bits, hex):
  - SET=01, ADD=02, SUB=03, MUL=04, MLI=05;
  - DIV=06, DVI=07, MOD=08, MDI=09;
  - AND=0a, BOR=0b, XOR=0c, SHR=0d, ASR=0e, SHL=0f;
  - IFB=10, IFC=11, IFE=12, IFN=13, IFG=14, IFA=15, IFL=16, IFU=17;
  - every other code is undefined.
- R4: ADD gives `b+a` mod 2^16, with excess 0x0001 on unsigned carry-out and 0 otherwise. SUB gives `b-a` mod 2^16, with excess 0xffff when `a>b` (unsigned) and 0 otherwise. Both write the excess.
- R5: MUL gives the low 16 bits of the unsigned 32-bit product, with the high 16 bits as excess. MLI does the same with both operands signed. Both write the excess.
- R6: DIV gives `b/a` and excess `((b<<16)/a)` mod 2^16, both unsigned. DVI does the same signed, rounding toward zero, and gives 0x8000 for 0x8000/0xffff. When `a` is 0, both the result and the excess of DIV and DVI are 0. Both write the excess.
- R7: MOD gives `b%a` unsigned. MDI gives the signed remainder, which takes the sign of `b` (0xfff9 mod 0x0010 = 0xfff9). When `a` is 0 both give 0. Neither writes the excess.
- R8: SHR gives `b>>a` (logical) with excess `((b<<16)>>a)` mod 2^16. ASR gives `b>>>a` (arithmetic) with the same excess rule using sign fill. `a` is the full 16-bit amount, and amounts of 16 or more shift everything out.
- R9: SHL gives `(b<<a)` mod 2^16, with excess equal to the bits pushed above bit 15, that is `((b<<a)>>16)` mod 2^16. Amounts of 16 or more give 0 as the result.
- R10: SET gives `a`. AND, BOR and XOR give the bitwise operation of `b` and `a`. None of them writes the excess (`excess_wr`=0, `excess`=0).
- R11: The conditions of the eight tests are:
  - IFB: `(b&a)!=0`;
  - IFC: `(b&a)==0`;
  - IFE: `b==a`;
  - IFN: `b!=a`;
  - IFG: `b>a` unsigned;
  - IFA: `b>a` signed;
  - IFL: `b<a` unsigned;
  - IFU: `b<a` signed.

  `skip` is 1 exactly when the condition of a test fails. A test writes neither the result nor the excess. `skip` is 0 for every non-test opcode.
- R12: After reset, `busy`, `done`, `result`, `result_wr`, `excess`, `excess_wr` and `skip` are all 0. After `done`, the outputs hold their values until the next accepted start.
- R13: An undefined opcode completes in 1 cycle with `result_wr`=0, `excess_wr`=0, `skip`=0 and zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch request, accepted when not busy |
| opcode | input | 5 | Operation code |
| opnd_b | input | 16 | Destination-side operand b |
| opnd_a | input | 16 | Source-side operand a |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | New value for b |
| result_wr | output | 1 | Result is meaningful and should be written |
| excess | output | 16 | New excess word |
| excess_wr | output | 1 | Excess word should be written |
| skip | output | 1 | Conditional test failed; next instruction is dropped |

## Verification
The assertions check the following on every cycle:

- `done` never lasts two cycles;
- the latched opcode cannot change while an operation is in flight;
- one-cycle and three-cycle operations reach `done` at the right edge;
- a zero divisor yields zeros;
- an addition's excess is only ever 0 or 1 and is written;
- `skip` and `result_wr` keep to their opcode classes.

The arithmetic values themselves can only be shown by the bench's scenarios. These include:

- random and boundary operands (0x8000, 0xffff, 0x7fff);
- shift amounts above 16;
- the signed overflow cases of division;
- the outcome-dependent latency of the tests;
- the dropping of a start request while busy;
- the holding of outputs after completion.

// File: rtl/exalu_pkg.sv
package exalu_pkg;

    localparam int OPW = 5;

    localparam logic [OPW-1:0] OP_SET = 5'h01;
    localparam logic [OPW-1:0] OP_ADD = 5'h02;
    localparam logic [OPW-1:0] OP_SUB = 5'h03;
    localparam logic [OPW-1:0] OP_MUL = 5'h04;
    localparam logic [OPW-1:0] OP_MLI = 5'h05;
    localparam logic [OPW-1:0] OP_DIV = 5'h06;
    localparam logic [OPW-1:0] OP_DVI = 5'h07;
    localparam logic [OPW-1:0] OP_MOD = 5'h08;
    localparam logic [OPW-1:0] OP_MDI = 5'h09;
    localparam logic [OPW-1:0] OP_AND = 5'h0a;
    localparam logic [OPW-1:0] OP_BOR = 5'h0b;
    localparam logic [OPW-1:0] OP_XOR = 5'h0c;
    localparam logic [OPW-1:0] OP_SHR = 5'h0d;
    localparam logic [OPW-1:0] OP_ASR = 5'h0e;
    localparam logic [OPW-1:0] OP_SHL = 5'h0f;
    localparam logic [OPW-1:0] OP_IFB = 5'h10;
    localparam logic [OPW-1:0] OP_IFC = 5'h11;
    localparam logic [OPW-1:0] OP_IFE = 5'h12;
    localparam logic [OPW-1:0] OP_IFN = 5'h13;
    localparam logic [OPW-1:0] OP_IFG = 5'h14;
    localparam logic [OPW-1:0] OP_IFA = 5'h15;
    localparam logic [OPW-1:0] OP_IFL = 5'h16;
    localparam logic [OPW-1:0] OP_IFU = 5'h17;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctl_state_e;

    // conditional tests occupy codes 0x10..0x17
    function automatic logic is_cond(input logic [OPW-1:0] op);
        return op[4:3] == 2'b10;
    endfunction

    // cost without the extra cycle of a failed test
    function automatic logic [1:0] cost_of(input logic [OPW-1:0] op);
        logic [1:0] c;
        if (is_cond(op))
            c = 2'd2;
        else if (op >= OP_ADD && op <= OP_MLI)
            c = 2'd2;
        else if (op >= OP_DIV && op <= OP_MDI)
            c = 2'd3;
        else
            c = 2'd1;
        return c;
    endfunction

endpackage

// File: rtl/exalu_ctrl.sv
module exalu_ctrl
    import exalu_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op_in,
    input  logic [OPW-1:0] op_q,
    input  logic           cond_fail,
    output logic           load,
    output logic           busy,
    output logic           done
);

    ctl_state_e     st, st_nx;
    logic [CW-1:0]  elapsed, elapsed_nx;
    logic [CW:0]    need;

    always_comb begin
        need = (CW+1)'(cost_of(op_q)) + (CW+1)'(is_cond(op_q) && cond_fail);
    end

    always_comb begin
        st_nx      = st;
        elapsed_nx = elapsed;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    elapsed_nx = CW'(1);
                    st_nx      = (cost_of(op_in) == 2'd1) ? ST_FIN : ST_RUN;
                end
            end
            ST_RUN: begin
                if ({1'b0, elapsed} + (CW+1)'(1) >= need)
                    st_nx = ST_FIN;
                else
                    elapsed_nx = elapsed + CW'(1);
            end
            ST_FIN: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            elapsed <= '0;
        end else begin
            st      <= st_nx;
            elapsed <= elapsed_nx;
        end
    end

    always_comb begin
        load = (st == ST_IDLE) && start;
        busy = (st != ST_IDLE);
        done = (st == ST_FIN);
    end

endmodule

// File: rtl/exalu_addshift.sv
module exalu_addshift
    import exalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    output logic           claim,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex,
    output logic           ex_wr
);

    localparam int W2 = 2 * W;

    logic [W:0]             sum;
    logic [W2-1:0]          wide_r;
    logic signed [W2-1:0]   wide_s;
    logic [W2-1:0]          wide_l;

    always_comb begin
        sum    = {1'b0, b} + {1'b0, a};
        wide_r = {b, {W{1'b0}}} >> a;
        wide_s = $signed({b, {W{1'b0}}}) >>> a;
        wide_l = {{W{1'b0}}, b} << a;
    end

    always_comb begin
        claim = 1'b1;
        res   = '0;
        ex    = '0;
        ex_wr = 1'b0;
        unique case (op)
            OP_SET: res = a;
            OP_AND: res = b & a;
            OP_BOR: res = b | a;
            OP_XOR: res = b ^ a;
            OP_ADD: begin
                res   = sum[W-1:0];
                ex    = {{(W-1){1'b0}}, sum[W]};
                ex_wr = 1'b1;
            end
            OP_SUB: begin
                res   = b - a;
                ex    = (a > b) ? '1 : '0;
                ex_wr = 1'b1;
            end
            OP_SHR: begin
                res   = wide_r[W2-1:W];
                ex    = wide_r[W-1:0];
                ex_wr = 1'b1;
            end
            OP_ASR: begin
                res   = wide_s[W2-1:W];
                ex    = wide_s[W-1:0];
                ex_wr = 1'b1;
            end
            OP_SHL: begin
                res   = wide_l[W-1:0];
                ex    = wide_l[W2-1:W];
                ex_wr = 1'b1;
            end
            default: claim = 1'b0;
        endcase
    end

endmodule

// File: rtl/exalu_muldiv.sv
module exalu_muldiv
    import exalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    output logic           claim,
    output logic [W-1:0]   res,
    output logic [W-1:0]   ex,
    output logic           ex_wr
);

    localparam int W2 = 2 * W;

    logic [W2-1:0]        prod_u;
    logic signed [W2-1:0] prod_s;
    logic signed [W2-1:0] b_sx;
    logic signed [W2-1:0] a_sx;
    logic                 a_zero;

    always_comb begin
        b_sx   = {{W{b[W-1]}}, b};
        a_sx   = {{W{a[W-1]}}, a};
        prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
        prod_s = b_sx * a_sx;
        a_zero = (a == '0);
    end

    always_comb begin
        claim = 1'b1;
        res   = '0;
        ex    = '0;
        ex_wr = 1'b0;
        unique case (op)
            OP_MUL: begin
                res   = prod_u[W-1:0];
                ex    = prod_u[W2-1:W];
                ex_wr = 1'b1;
            end
            OP_MLI: begin
                res   = prod_s[W-1:0];
                ex    = prod_s[W2-1:W];
                ex_wr = 1'b1;
            end
            OP_DIV: begin
                ex_wr = 1'b1;
                if (!a_zero) begin
                    res = b / a;
                    ex  = W'({b, {W{1'b0}}} / {{W{1'b0}}, a});
                end
            end
            OP_DVI: begin
                ex_wr = 1'b1;
                if (!a_zero) begin
                    res = W'(b_sx / a_sx);
                    ex  = W'($signed({{W{b[W-1]}}, b, {W{1'b0}}})
                             / $signed({{W2{a[W-1]}}, a}));
                end
            end
            OP_MOD: begin
                if (!a_zero) res = b % a;
            end
            OP_MDI: begin
                if (!a_zero) res = W'(b_sx % a_sx);
            end
            default: claim = 1'b0;
        endcase
    end

endmodule

// File: rtl/exalu_cmp.sv
module exalu_cmp
    import exalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   a,
    output logic           claim,
    output logic           cond_fail
);

    logic holds;

    always_comb begin
        claim = is_cond(op);
        unique case (op[2:0])
            3'd0: holds = (b & a) != '0;
            3'd1: holds = (b & a) == '0;
            3'd2: holds = (b == a);
            3'd3: holds = (b != a);
            3'd4: holds = (b > a);
            3'd5: holds = ($signed(b) > $signed(a));
            3'd6: holds = (b < a);
            3'd7: holds = ($signed(b) < $signed(a));
            default: holds = 1'b0;
        endcase
        cond_fail = claim && !holds;
    end

endmodule

// File: rtl/exalu_core.sv
module exalu_core
    import exalu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] opcode,
    input  logic [W-1:0]   opnd_b,
    input  logic [W-1:0]   opnd_a,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   result,
    output logic           result_wr,
    output logic [W-1:0]   excess,
    output logic           excess_wr,
    output logic           skip
);

    logic [OPW-1:0] op_q;
    logic [W-1:0]   b_q, a_q;
    logic           load;

    logic           as_claim, as_exw;
    logic [W-1:0]   as_res, as_ex;
    logic           md_claim, md_exw;
    logic [W-1:0]   md_res, md_ex;
    logic           cm_claim, cm_fail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= '0;
            b_q  <= '0;
            a_q  <= '0;
        end else if (load) begin
            op_q <= opcode;
            b_q  <= opnd_b;
            a_q  <= opnd_a;
        end
    end

    exalu_ctrl #(.CW(2)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (opcode),
        .op_q      (op_q),
        .cond_fail (cm_fail),
        .load      (load),
        .busy      (busy),
        .done      (done)
    );

    exalu_addshift #(.W(W)) u_addshift (
        .op    (op_q),
        .b     (b_q),
        .a     (a_q),
        .claim (as_claim),
        .res   (as_res),
        .ex    (as_ex),
        .ex_wr (as_exw)
    );

    exalu_muldiv #(.W(W)) u_muldiv (
        .op    (op_q),
        .b     (b_q),
        .a     (a_q),
        .claim (md_claim),
        .res   (md_res),
        .ex    (md_ex),
        .ex_wr (md_exw)
    );

    exalu_cmp #(.W(W)) u_cmp (
        .op        (op_q),
        .b         (b_q),
        .a         (a_q),
        .claim     (cm_claim),
        .cond_fail (cm_fail)
    );

    always_comb begin
        result    = '0;
        result_wr = 1'b0;
        excess    = '0;
        excess_wr = 1'b0;
        if (as_claim) begin
            result    = as_res;
            result_wr = 1'b1;
            excess    = as_ex;
            excess_wr = as_exw;
        end else if (md_claim) begin
            result    = md_res;
            result_wr = 1'b1;
            excess    = md_ex;
            excess_wr = md_exw;
        end
        skip = cm_claim && cm_fail;
    end

endmodule

// File: rtl/exalu_chk.sv
module exalu_chk
    import exalu_pkg::*;
#(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [OPW-1:0] opcode,
    input logic           busy,
    input logic           done,
    input logic [OPW-1:0] op_q,
    input logic [W-1:0]   a_q,
    input logic [W-1:0]   result,
    input logic           result_wr,
    input logic [W-1:0]   excess,
    input logic           excess_wr,
    input logic           skip
);

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));

    // R2
    quick_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (opcode == OP_SET || opcode == OP_AND || opcode == OP_SHL))
        |=> done);

    // R2
    div_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode == OP_DIV) |=> !done ##1 !done ##1 done);

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_DIV || op_q == OP_DVI) && a_q == '0)
        |-> (result == '0 && excess == '0));

    // R4
    add_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_ADD) |-> (excess <= W'(1) && excess_wr));

    // R11
    skip_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> is_cond(op_q));

    // R11
    test_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_cond(op_q)) |-> (!result_wr && !excess_wr));

endmodule

bind exalu_core exalu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .opcode    (opcode),
    .busy      (busy),
    .done      (done),
    .op_q      (op_q),
    .a_q       (a_q),
    .result    (result),
    .result_wr (result_wr),
    .excess    (excess),
    .excess_wr (excess_wr),
    .skip      (skip)
);

// File: tb/exalu_core_tb.sv
module exalu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  opcode = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] opnd_a = '0;
    logic        busy, done, result_wr, excess_wr, skip;
    logic [15:0] result, excess;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    exalu_core u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .opnd_b    (opnd_b),
        .opnd_a    (opnd_a),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .result_wr (result_wr),
        .excess    (excess),
        .excess_wr (excess_wr),
        .skip      (skip)
    );

    typedef struct {
        logic [15:0] res;
        logic [15:0] ex;
        bit          resw;
        bit          exw;
        bit          skp;
        int          cost;
    } exp_t;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic string tag_of(input logic [4:0] o);
        if (o == 5'h01 || (o >= 5'h0a && o <= 5'h0c)) return "R10";
        if (o == 5'h02 || o == 5'h03) return "R4";
        if (o == 5'h04 || o == 5'h05) return "R5";
        if (o == 5'h06 || o == 5'h07) return "R6";
        if (o == 5'h08 || o == 5'h09) return "R7";
        if (o == 5'h0d || o == 5'h0e) return "R8";
        if (o == 5'h0f) return "R9";
        if (o >= 5'h10 && o <= 5'h17) return "R11";
        return "R13";
    endfunction

    // reference model built from the requirements (R3 encodings)
    function automatic exp_t model(input logic [4:0] o, input logic [15:0] b,
                                   input logic [15:0] a);
        exp_t e;
        longint sb, sa, ub, ua, v;
        logic [31:0] t;
        int n;
        bit c;
        sb = longint'($signed(b));
        sa = longint'($signed(a));
        ub = longint'(b);
        ua = longint'(a);
        n  = (ua > 40) ? 40 : int'(ua);
        e.res = 0; e.ex = 0; e.resw = 0; e.exw = 0; e.skp = 0; e.cost = 1;
        case (o)
            5'h01: begin e.res = a; e.resw = 1; end
            5'h0a: begin e.res = b & a; e.resw = 1; end
            5'h0b: begin e.res = b | a; e.resw = 1; end
            5'h0c: begin e.res = b ^ a; e.resw = 1; end
            5'h02: begin
                v = ub + ua; e.res = v[15:0]; e.ex = (v > 65535) ? 16'h1 : 16'h0;
                e.resw = 1; e.exw = 1; e.cost = 2;
            end
            5'h03: begin
                v = ub - ua; e.res = v[15:0]; e.ex = (ua > ub) ? 16'hffff : 16'h0;
                e.resw = 1; e.exw = 1; e.cost = 2;
            end
            5'h04: begin
                v = ub * ua; e.res = v[15:0]; e.ex = v[31:16];
                e.resw = 1; e.exw = 1; e.cost = 2;
            end
            5'h05: begin
                v = sb * sa; e.res = v[15:0]; e.ex = v[31:16];
                e.resw = 1; e.exw = 1; e.cost = 2;
            end
            5'h06: begin
                e.resw = 1; e.exw = 1; e.cost = 3;
                if (a != 0) begin
                    v = ub / ua; e.res = v[15:0];
                    v = (ub * 65536) / ua; e.ex = v[15:0];
                end
            end
            5'h07: begin
                e.resw = 1; e.exw = 1; e.cost = 3;
                if (a != 0) begin
                    v = sb / sa; e.res = v[15:0];
                    v = (sb * 65536) / sa; e.ex = v[15:0];
                end
            end
            5'h08: begin
                e.resw = 1; e.cost = 3;
                if (a != 0) begin v = ub % ua; e.res = v[15:0]; end
            end
            5'h09: begin
                e.resw = 1; e.cost = 3;
                if (a != 0) begin v = sb % sa; e.res = v[15:0]; end
            end
            5'h0d: begin
                t = {b, 16'h0};
                for (int i = 0; i < n; i++) t = {1'b0, t[31:1]};
                e.res = t[31:16]; e.ex = t[15:0]; e.resw = 1; e.exw = 1;
            end
            5'h0e: begin
                t = {b, 16'h0};
                for (int i = 0; i < n; i++) t = {t[31], t[31:1]};
                e.res = t[31:16]; e.ex = t[15:0]; e.resw = 1; e.exw = 1;
            end
            5'h0f: begin
                t = {16'h0, b};
                for (int i = 0; i < n; i++) t = {t[30:0], 1'b0};
                e.res = t[15:0]; e.ex = t[31:16]; e.resw = 1; e.exw = 1;
            end
            5'h10, 5'h11, 5'h12, 5'h13, 5'h14, 5'h15, 5'h16, 5'h17: begin
                case (o)
                    5'h10: c = (b & a) != 0;
                    5'h11: c = (b & a) == 0;
                    5'h12: c = (b == a);
                    5'h13: c = (b != a);
                    5'h14: c = (ub > ua);
                    5'h15: c = (sb > sa);
                    5'h16: c = (ub < ua);
                    default: c = (sb < sa);
                endcase
                e.skp = !c; e.cost = c ? 2 : 3;
            end
            default: ;
        endcase
        return e;
    endfunction

    task automatic launch(input logic [4:0] o, input logic [15:0] b, input logic [15:0] a);
        @(negedge clk);
        start = 1'b1; opcode = o; opnd_b = b; opnd_a = a;
    endtask

    task automatic compare(input logic [4:0] o, input logic [15:0] b,
                           input logic [15:0] a, input int cyc);
        exp_t e;
        string tg;
        e  = model(o, b, a);
        tg = tag_of(o);
        chk(cyc == e.cost, "R2", $sformatf("latency op=%h", o), cyc, e.cost);
        chk(result == e.res, tg, $sformatf("result op=%h b=%h a=%h", o, b, a), result, e.res);
        chk(excess == e.ex, tg, $sformatf("excess op=%h b=%h a=%h", o, b, a), excess, e.ex);
        chk(result_wr == e.resw && excess_wr == e.exw, tg, $sformatf("write enables op=%h", o),
            {result_wr, excess_wr}, {e.resw, e.exw});
        chk(skip == e.skp, tg, $sformatf("skip op=%h b=%h a=%h", o, b, a), skip, e.skp);
    endtask

    task automatic run(input logic [4:0] o, input logic [15:0] b, input logic [15:0] a);
        int cyc;
        launch(o, b, a);
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 8);
        compare(o, b, a, cyc);
    endtask

    function automatic logic [15:0] pick();
        case ($urandom_range(0, 9))
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7fff;
            3: return 16'h8000;
            4: return 16'hffff;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] keep_r, keep_e;
        int cyc;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(!busy && !done && result == 0 && excess == 0 && !skip && !result_wr && !excess_wr,
            "R12", "reset outputs", {busy, done, result, excess, skip}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run(5'h02, 16'hffff, 16'h0001);   // R4 carry
        run(5'h03, 16'h0000, 16'h0001);   // R4 borrow
        run(5'h05, 16'h8000, 16'h8000);   // R5
        run(5'h04, 16'hffff, 16'hffff);   // R5
        run(5'h06, 16'h1234, 16'h0000);   // R6 zero divisor
        run(5'h07, 16'h8000, 16'hffff);   // R6 signed overflow
        run(5'h07, 16'hfff9, 16'h0002);   // R6 truncation
        run(5'h09, 16'hfff9, 16'h0010);   // R7 sign of b
        run(5'h08, 16'h0042, 16'h0000);   // R7 zero
        run(5'h0d, 16'h8001, 16'h0001);   // R8
        run(5'h0e, 16'h8000, 16'h0014);   // R8 beyond width
        run(5'h0f, 16'hffff, 16'h0010);   // R9 amount 16
        run(5'h0f, 16'h8421, 16'h0004);   // R9
        run(5'h01, 16'h1111, 16'habcd);   // R10
        run(5'h15, 16'h8000, 16'h7fff);   // R11 signed fail
        run(5'h14, 16'h8000, 16'h7fff);   // R11 unsigned pass
        run(5'h17, 16'h8000, 16'h0000);   // R11
        run(5'h00, 16'h1234, 16'h5678);   // R13
        run(5'h1f, 16'h1234, 16'h5678);   // R13

        // R1: start while busy is ignored
        launch(5'h06, 16'h0064, 16'h0007);
        @(negedge clk);
        opcode = 5'h0a; opnd_b = 16'hffff; opnd_a = 16'h0f0f;
        cyc = 1;
        while (!done && cyc < 8) begin
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        compare(5'h06, 16'h0064, 16'h0007, cyc);
        chk(busy, "R1", "busy at done", busy, 1);

        // R12 hold after done; R1 done one cycle
        keep_r = result; keep_e = excess;
        @(negedge clk);
        chk(!done, "R1", "done single cycle", done, 0);
        @(negedge clk);
        chk(result == keep_r && excess == keep_e && !busy, "R12", "outputs held",
            {result, excess}, {keep_r, keep_e});

        // constrained random
        for (int k = 0; k < 1500; k++) begin
            logic [4:0]  o;
            logic [15:0] b, a;
            o = 5'($urandom_range(0, 31));
            b = pick();
            a = pick();
            if (o >= 5'h0d && o <= 5'h0f && $urandom_range(0, 1) == 1)
                a = 16'($urandom_range(0, 20));
            if (o >= 5'h10 && o <= 5'h17 && $urandom_range(0, 3) == 0)
                a = b;
            run(o, b, a);
        end

        finish_run();
    end

endmodule